// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a cycle-accurate, synthesizable model of a synchronous static memory built so that the shared data bus never needs an idle cycle when it switches between reading and writing. Each enabled clock edge samples one command: an address, a read/write select, a load-or-advance select, three chip enables and four per-byte write strobes. The data for that command moves exactly two enabled edges later, whether it is a read or a write. The word is 36 bits wide, made of four 9-bit bytes. The depth is a parameter, so a small array can stand in for a larger device.

One supplied address can drive a four-word burst. An internal 2-bit counter steps either linearly or in interleaved order. The bidirectional pad is split into `din`, `dout` and an output-valid flag `dout_en`.

The data interface uses fixed latency and has no valid/ready handshake. The only way to stall is the active-low clock enable, which freezes every register in the block. A master must therefore present write data, and accept read data, in the cycle that the two-cycle latency dictates. Output enable and sleep only gate the outputs.

Top module: `zbt_sram`

## Requirements
- R1: A read command sampled on enabled edge E puts the stored word on `dout` with `dout_en`=1 right after enabled edge E+2. A write command sampled on edge E stores the `din` value present at enabled edge E+2.
- R2: Reads and writes may be issued on consecutive enabled edges, in any order and to any address, with no idle cycle between them. A read issued after a write to the same address returns the written data.
- R3: While `clk_en_n` is 1, every input apart from `oe_n` and `sleep` is ignored. All pipeline, burst and output registers hold their values, and no memory write takes place.
- R4: The device is selected only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A load cycle (`adv_ld`=0) without selection starts no operation, but commands already in the pipeline still complete.
- R5: After a write command or a deselected cycle, `dout_en` is 0 two enabled edges later. Whenever `dout_en` is 0, `dout` reads all zeros.
- R6: A cycle with `adv_ld`=1 continues the current burst. It uses the direction of the most recent load, keeps address bits above bit 1 fixed, and takes that cycle's byte strobes. An advance after a deselected load does nothing.
- R7: With `burst_ilv`=0, the low two address bits of burst word n are (base + n) mod 4. With `burst_ilv`=1 they are base XOR n, where n counts from 0 at the load.
- R8: Byte i of the word is bits [9i+8:9i]. During a write, byte i is updated only if `byte_wr_n[i]`=0, and the other bytes keep their old value.
- R9: `oe_n`=1 forces `dout_en` to 0 at once and does not disturb the pipeline. A read in flight is visible again as soon as `oe_n` returns to 0.
- R10: While `sleep`=1, commands are treated as deselected, the burst state is left alone, `dout_en` is 0 and the memory contents are kept. Normal commands are accepted again from the first enabled edge after `sleep` falls.
- R11: After reset, `dout_en` is 0, no burst is active and the pipeline holds no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; 1 freezes the block |
| sleep | input | 1 | Low-power hold: ignore commands, outputs off |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| wr_n | input | 1 | 1 read, 0 write (sampled on load cycles) |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| byte_wr_n | input | 4 | Per-byte write strobes, active low |
| addr | input | AW | Word address |
| burst_ilv | input | 1 | 0 linear burst order, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data, sampled in the data phase |
| dout | output | 36 | Read data, zero when not driven |
| dout_en | output | 1 | Read data is being driven |

## Verification
The case that matters most is a write's data phase landing on the same edge as a command that reads the same word. It is provoked by issuing write and read to one address on back-to-back edges, and judged by the read returning the new data two edges after its own command. A second collision is a clock-enable stall over a cycle in which a read is leaving the pipeline while a write command sits on the pins. The bench judges it by `dout` staying frozen, the read completing after the stall, and the stalled write never appearing in later reads. Each cycle is compared against a reference model that the bench builds from the requirements.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl
  import zbt_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sleep,
  input  logic          adv_ld,
  input  logic          wr_n,
  input  logic          selected,
  input  logic          burst_ilv,
  input  logic [AW-1:0] addr,
  output op_e           cmd_op,
  output logic [AW-1:0] cmd_addr
);
  localparam int CW = 2;

  logic          active_q;
  logic          dir_wr_q;
  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic [CW-1:0] low_bits;

  assign cnt_nxt  = cnt_q + CW'(1);
  assign low_bits = burst_ilv ? (base_q[CW-1:0] ^ cnt_nxt)
                              : (base_q[CW-1:0] + cnt_nxt);

  always_comb begin
    cmd_op   = OP_IDLE;
    cmd_addr = addr;
    if (!sleep) begin
      if (!adv_ld) begin
        if (selected) cmd_op = wr_n ? OP_READ : OP_WRITE;
      end else if (active_q) begin
        cmd_op   = dir_wr_q ? OP_WRITE : OP_READ;
        cmd_addr = {base_q[AW-1:CW], low_bits};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_wr_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (en && !sleep) begin
      if (!adv_ld) begin
        active_q <= selected;
        dir_wr_q <= !wr_n;
        base_q   <= addr;
        cnt_q    <= '0;
      end else if (active_q) begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  // R6: an advance inside an active burst steps the counter by one
  assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sleep && adv_ld && active_q) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R10: sleep leaves the burst state untouched
  assert_sleep_keeps_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sleep) |=> ($stable(base_q) && $stable(cnt_q) && $stable(active_q)));
endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
  import zbt_pkg::*;
#(
  parameter int AW      = 8,
  parameter int NBYTES  = 4,
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_e               in_op,
  input  logic [AW-1:0]     in_addr,
  input  logic [NBYTES-1:0] in_bw_n,
  output op_e               head_op,
  output op_e               out_op,
  output logic [AW-1:0]     out_addr,
  output logic [NBYTES-1:0] out_bw_n
);
  localparam int OPW = 2;
  localparam int SW  = OPW + AW + NBYTES;

  logic [SW-1:0] in_vec;
  logic [SW-1:0] stg [LATENCY];

  assign in_vec = {in_op, in_addr, in_bw_n};

  for (genvar g = 0; g < LATENCY; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stg[g] <= '0;
        else if (en) stg[g] <= in_vec;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stg[g] <= '0;
        else if (en) stg[g] <= stg[g-1];
      end
    end
  end

  assign head_op  = op_e'(stg[0][SW-1 -: OPW]);
  assign out_op   = op_e'(stg[LATENCY-1][SW-1 -: OPW]);
  assign out_addr = stg[LATENCY-1][NBYTES +: AW];
  assign out_bw_n = stg[LATENCY-1][NBYTES-1:0];

  // R3: a disabled clock freezes every in-flight command
  assert_pipe_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(head_op) && $stable(out_op) && $stable(out_addr)));
endmodule

// File: rtl/zbt_array.sv
module zbt_array
  import zbt_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  op_e                      op,
  input  logic [AW-1:0]            addr,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic [NBYTES*BYTE_W-1:0] din,
  output logic [NBYTES*BYTE_W-1:0] rdata_q,
  output logic                     rvld_q
);
  localparam int WW    = NBYTES * BYTE_W;
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && op == OP_WRITE) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (!bw_n[b]) mem[addr][b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q  <= 1'b0;
      rdata_q <= '0;
    end else if (en) begin
      rvld_q <= (op == OP_READ);
      if (op == OP_READ) rdata_q <= mem[addr];
    end
  end

  // R1: a read in its data phase drives the output one edge later
  assert_read_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_READ) |=> rvld_q);

  // R5: a write or idle data phase turns the output off
  assert_off_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op != OP_READ) |=> !rvld_q);

  // R3: no output change while the clock is disabled
  assert_out_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(rvld_q) && $stable(rdata_q)));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int AW     = 8,
  parameter int NBYTES = 4,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clk_en_n,
  input  logic                     sleep,
  input  logic                     adv_ld,
  input  logic                     wr_n,
  input  logic                     ce_a_n,
  input  logic                     ce_b,
  input  logic                     ce_c_n,
  input  logic [NBYTES-1:0]        byte_wr_n,
  input  logic [AW-1:0]            addr,
  input  logic                     burst_ilv,
  input  logic                     oe_n,
  input  logic [NBYTES*BYTE_W-1:0] din,
  output logic [NBYTES*BYTE_W-1:0] dout,
  output logic                     dout_en
);
  localparam int WW      = NBYTES * BYTE_W;
  localparam int LATENCY = 2;

  logic              en;
  logic              selected;
  op_e               cmd_op;
  logic [AW-1:0]     cmd_addr;
  op_e               head_op;
  op_e               dp_op;
  logic [AW-1:0]     dp_addr;
  logic [NBYTES-1:0] dp_bw_n;
  logic [WW-1:0]     rdata_q;
  logic              rvld_q;

  assign en       = !clk_en_n;
  assign selected = !ce_a_n && ce_b && !ce_c_n;

  zbt_burst_ctl #(.AW(AW)) u_burst (
    .clk(clk), .rst_n(rst_n), .en(en), .sleep(sleep), .adv_ld(adv_ld),
    .wr_n(wr_n), .selected(selected), .burst_ilv(burst_ilv), .addr(addr),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  zbt_cmd_pipe #(.AW(AW), .NBYTES(NBYTES), .LATENCY(LATENCY)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(en), .in_op(cmd_op), .in_addr(cmd_addr),
    .in_bw_n(byte_wr_n), .head_op(head_op), .out_op(dp_op),
    .out_addr(dp_addr), .out_bw_n(dp_bw_n)
  );

  zbt_array #(.AW(AW), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .en(en), .op(dp_op), .addr(dp_addr),
    .bw_n(dp_bw_n), .din(din), .rdata_q(rdata_q), .rvld_q(rvld_q)
  );

  assign dout_en = rvld_q && !oe_n && !sleep;
  assign dout    = dout_en ? rdata_q : '0;

  // R4: a load without full selection admits no command
  assert_deselect_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sleep && !adv_ld && !selected) |=> (head_op == OP_IDLE));

  // R10: sleep admits no command
  assert_sleep_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sleep) |=> (head_op == OP_IDLE));

  // R11: nothing is driven in the first cycle after reset
  assert_reset_quiet_R11: assert property (@(posedge clk)
    $rose(rst_n) |-> !rvld_q);
endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en_n = 1'b0, sleep = 1'b0, adv_ld = 1'b0, wr_n = 1'b1;
  logic        ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
  logic [3:0]  byte_wr_n = 4'hF;
  logic [7:0]  addr = '0;
  logic        burst_ilv = 1'b0, oe_n = 1'b0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        dout_en;

  always #10 clk = ~clk;

  zbt_sram #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sleep(sleep),
    .adv_ld(adv_ld), .wr_n(wr_n), .ce_a_n(ce_a_n), .ce_b(ce_b),
    .ce_c_n(ce_c_n), .byte_wr_n(byte_wr_n), .addr(addr),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .din(din), .dout(dout),
    .dout_en(dout_en)
  );

  int n_chk = 0, n_bad = 0;
  logic [35:0] ref_mem [256];
  bit          ref_known [256];
  int          p_op [2];
  logic [7:0]  p_addr [2];
  logic [3:0]  p_bw [2];
  bit          m_active = 0, m_dir = 0;
  logic [7:0]  m_base = '0;
  logic [1:0]  m_cnt = '0;
  bit          exp_en = 0, exp_known = 0;
  logic [35:0] exp_data = '0;
  logic [11:0] g_seed = 12'h3C5;

  task automatic check(bit ok, string tag, logic [35:0] act, logic [35:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [35:0] mk(logic [7:0] a);
    return {a[3:0], a, a ^ 8'h5A, g_seed, 4'h9};
  endfunction

  // one clock cycle: drive, update reference, check outputs at the next falling edge
  task automatic cyc(bit cen_n, bit adl, bit wrn, logic [2:0] sel, logic [3:0] bwn,
                     logic [7:0] a, string tag);
    int op;
    logic [7:0] oa;
    bit s;
    clk_en_n = cen_n; adv_ld = adl; wr_n = wrn;
    {ce_a_n, ce_b, ce_c_n} = sel; byte_wr_n = bwn; addr = a;
    din = (p_op[1] == 2) ? mk(p_addr[1]) : mk(~a);
    if (!cen_n) begin
      if (p_op[1] == 2) begin
        for (int b = 0; b < 4; b++)
          if (!p_bw[1][b]) ref_mem[p_addr[1]][b*9 +: 9] = din[b*9 +: 9];
        if (p_bw[1] == 4'h0) ref_known[p_addr[1]] = 1;
      end
      exp_en = (p_op[1] == 1);
      if (exp_en) begin
        exp_data = ref_mem[p_addr[1]];
        exp_known = ref_known[p_addr[1]];
      end
      op = 0; oa = a;
      if (!sleep) begin
        if (!adl) begin
          s = (sel == 3'b010);
          m_active = s; m_base = a; m_cnt = 2'd0; m_dir = !wrn;
          if (s) op = wrn ? 1 : 2;
        end else if (m_active) begin
          m_cnt = m_cnt + 2'd1;
          op = m_dir ? 2 : 1;
          oa = {m_base[7:2], burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
        end
      end
      p_op[1] = p_op[0]; p_addr[1] = p_addr[0]; p_bw[1] = p_bw[0];
      p_op[0] = op; p_addr[0] = oa; p_bw[0] = bwn;
    end
    @(negedge clk);
    begin
      bit want;
      want = exp_en && !oe_n && !sleep;
      check(dout_en == want, {tag, " dout_en"}, 36'(dout_en), 36'(want));
      if (!want) check(dout == 36'h0, {tag, " dout idle zero (R5)"}, dout, 36'h0);
      else if (exp_known) check(dout == exp_data, {tag, " dout data"}, dout, exp_data);
    end
  endtask

  task automatic ld(bit wrn, logic [7:0] a, logic [3:0] bwn, string tag);
    cyc(0, 0, wrn, 3'b010, bwn, a, tag);
  endtask
  task automatic adv(logic [3:0] bwn, string tag);
    cyc(0, 1, 1, 3'b111, bwn, 8'hFF, tag);
  endtask
  task automatic nop(string tag);
    cyc(0, 0, 1, 3'b100, 4'hF, 8'h00, tag);
  endtask
  task automatic drain(string tag);
    nop(tag); nop(tag); nop(tag);
  endtask

  task automatic t_reset();
    check(dout_en == 1'b0, "R11 reset dout_en", 36'(dout_en), 36'h0);
    check(dout == 36'h0, "R11 reset dout", dout, 36'h0);
    adv(4'h0, "R11 advance after reset idle");
    adv(4'h0, "R11"); nop("R11"); nop("R11");
  endtask

  task automatic t_single();
    ld(0, 8'h10, 4'h0, "R1 write"); nop("R1"); nop("R1");
    ld(1, 8'h10, 4'hF, "R1 read"); nop("R1"); nop("R1 read data");
    drain("R1");
  endtask

  task automatic t_turnaround();
    g_seed = 12'h1A7;
    ld(0, 8'h20, 4'h0, "R2 w20"); ld(1, 8'h10, 4'hF, "R2 r10");
    ld(0, 8'h21, 4'h0, "R2 w21"); ld(1, 8'h20, 4'hF, "R2 r20");
    ld(0, 8'h22, 4'h0, "R2 w22"); ld(1, 8'h22, 4'hF, "R2 r22 after w22");
    ld(1, 8'h21, 4'hF, "R2 r21"); ld(0, 8'h21, 4'h0, "R2 w21 after read");
    ld(1, 8'h21, 4'hF, "R2 r21 new");
    drain("R2");
  endtask

  task automatic t_burst();
    g_seed = 12'h6E1;
    burst_ilv = 0;
    ld(0, 8'h4E, 4'h0, "R6 linear write"); adv(4'h0, "R7 lin");
    adv(4'h0, "R7 lin"); adv(4'h0, "R7 lin wrap");
    ld(1, 8'h4C, 4'hF, "R6 read base"); adv(4'hF, "R7"); adv(4'hF, "R7");
    adv(4'hF, "R7"); adv(4'hF, "R6 fifth word wraps");
    burst_ilv = 1;
    ld(1, 8'h4D, 4'hF, "R7 ilv read"); adv(4'hF, "R7 ilv");
    adv(4'hF, "R7 ilv"); adv(4'hF, "R7 ilv");
    g_seed = 12'h0B3;
    ld(0, 8'h51, 4'h0, "R7 ilv write"); adv(4'h0, "R7"); adv(4'h0, "R7"); adv(4'h0, "R7");
    burst_ilv = 0;
    ld(1, 8'h50, 4'hF, "R7 ilv readback"); adv(4'hF, "R7"); adv(4'hF, "R7"); adv(4'hF, "R7");
    nop("R6 deselect load"); adv(4'h0, "R6 advance while deselected"); adv(4'h0, "R6");
    drain("R6");
  endtask

  task automatic t_bytes();
    g_seed = 12'hAAA;
    ld(0, 8'h30, 4'h0, "R8 full"); nop("R8"); nop("R8");
    g_seed = 12'h555;
    ld(0, 8'h30, 4'b1010, "R8 bytes 0 and 2"); nop("R8"); nop("R8");
    g_seed = 12'h0F0;
    ld(0, 8'h30, 4'b0111, "R8 byte 3"); nop("R8"); nop("R8");
    ld(1, 8'h30, 4'hF, "R8 merged read"); drain("R8 merged");
  endtask

  task automatic t_stall();
    ld(1, 8'h20, 4'hF, "R3 read before stall"); nop("R3");
    cyc(1, 0, 0, 3'b010, 4'h0, 8'h22, "R3 stalled write");
    cyc(1, 0, 0, 3'b010, 4'h0, 8'h21, "R3 stalled write");
    cyc(1, 1, 0, 3'b010, 4'h0, 8'h21, "R3 stalled advance");
    nop("R3 read after stall"); nop("R3");
    ld(1, 8'h22, 4'hF, "R3 stalled write absent"); ld(1, 8'h21, 4'hF, "R3");
    drain("R3");
    ld(1, 8'h10, 4'hF, "R3 stall on data phase"); nop("R3"); nop("R3 out");
    cyc(1, 0, 1, 3'b010, 4'hF, 8'h20, "R3 held output");
    cyc(1, 0, 1, 3'b010, 4'hF, 8'h20, "R3 held output");
    drain("R3");
  endtask

  task automatic t_deselect();
    g_seed = 12'h777;
    ld(0, 8'h60, 4'h0, "R4 write");
    cyc(0, 0, 0, 3'b110, 4'h0, 8'h10, "R4 ce_a_n high");
    cyc(0, 0, 0, 3'b000, 4'h0, 8'h10, "R4 ce_b low");
    cyc(0, 0, 0, 3'b011, 4'h0, 8'h10, "R4 ce_c_n high");
    ld(1, 8'h60, 4'hF, "R4 pending write done"); ld(1, 8'h10, 4'hF, "R4 r10 intact");
    cyc(0, 0, 1, 3'b110, 4'hF, 8'h60, "R5 deselect after read"); nop("R5"); nop("R5 off");
  endtask

  task automatic t_oe();
    ld(1, 8'h4C, 4'hF, "R9"); adv(4'hF, "R9"); adv(4'hF, "R9");
    oe_n = 1; adv(4'hF, "R9 forced off");
    oe_n = 0; nop("R9 back on"); nop("R9"); nop("R9");
  endtask

  task automatic t_sleep();
    sleep = 1;
    ld(0, 8'h10, 4'h0, "R10 write ignored"); ld(1, 8'h10, 4'hF, "R10 outputs off");
    nop("R10"); nop("R10");
    sleep = 0;
    ld(1, 8'h10, 4'hF, "R10 resumed read"); drain("R10 content kept");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin ref_mem[i] = '0; ref_known[i] = 0; end
    for (int i = 0; i < 2; i++) begin p_op[i] = 0; p_addr[i] = '0; p_bw[i] = 4'hF; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_turnaround();
    t_burst();
    t_bytes();
    t_stall();
    t_deselect();
    t_oe();
    t_sleep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule